// File: doc/BRIEF.md
# Preemptive Interrupt Priority Arbiter

This block watches a set of interrupt source lines. Each source has a programmable 4-bit priority, and its vector number is its own index. The block holds the priority of the handler that is running now. It raises one registered request to the processor when an asserted source is strictly more urgent than that running level. When the request rises, the block captures the winning source's index as the acknowledge vector.

The processor acknowledges by reading that vector. The block then saves the running level on a bounded save stack and adopts the priority of the captured winner. At the end of the handler, an end-of-interrupt write pops the stack and restores the level that was interrupted. No search is made for the source that was interrupted: any source at or below the restored level stays silent. When the stack overflows, the oldest saved levels are lost. Popping an empty stack yields level 0, which regenerates the bottom level that was dropped.

Top module: `irq_preempt_arb`

## Requirements
- R1: `cpu_irq` is a register. One cycle after some asserted source has a priority strictly greater than `cur_prio`, it is 1. Otherwise it is 0 one cycle later.
- R2: The winner is the source with the highest priority. Ties go to the lowest source index. A source programmed with priority 0 never wins.
- R3: `ack_vec` loads the winner's index on the same edge on which `cpu_irq` goes from 0 to 1. At all other times it holds, even when a more urgent source appears while `cpu_irq` stays high.
- R4: When `ack_rd` is 1 while `cpu_irq` is 1, three things happen on the next edge. The old `cur_prio` is pushed on the save stack, `cur_prio` takes the priority the winner had when `cpu_irq` rose, and `cpu_irq` goes to 0.
- R5: When `ack_rd` is 1 while `cpu_irq` is 0, it has no effect on `cur_prio` or on the stack.
- R6: A pulse on `eoi_wr` pops the save stack, and `cur_prio` takes the popped value on the next edge. `cur_prio` changes only on an accepted acknowledge or an end-of-interrupt write. If both arrive in the same cycle, the acknowledge is taken and the end-of-interrupt write is dropped.
- R7: The save stack holds `STACK_DEPTH` levels (14 by default). A push onto a full stack discards the oldest entry. A pop with nothing saved returns 0.
- R8: After a restore, asserted sources at or below the restored level cause no request, and that includes the source that was interrupted.
- R9: While `cur_prio` is 15, `cpu_irq` stays 0 whatever the sources do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | NUM_SRC | Request line of each source |
| src_prio | input | 4*NUM_SRC | Priority of each source; source i is in bits [4i+3:4i] |
| ack_rd | input | 1 | One-cycle pulse: the processor reads the acknowledge vector |
| eoi_wr | input | 1 | One-cycle pulse: end-of-interrupt write |
| cpu_irq | output | 1 | Registered request to the processor |
| ack_vec | output | $clog2(NUM_SRC) | Index of the source that won when the request last rose |
| cur_prio | output | 4 | Running priority level |

## Verification
The assertions take for granted that `ack_rd` and `eoi_wr` are never high in the same cycle, and that the source lines are free to change on any cycle. The stimulus keeps to this by issuing acknowledges and end-of-interrupt writes as separate one-cycle pulses, with idle cycles in between. Request patterns are driven exhaustively over eight sources under two priority tables, one with no ties and one with pairwise ties. Stack overflow is reached by reprogramming one source up through every level before the stack is unwound.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int PRIO_W = 4;
  localparam logic [PRIO_W-1:0] PRIO_TOP = '1;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irq_win_sel.sv
module irq_win_sel
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [PRIO_W*NUM_SRC-1:0] prio_flat,
  input  prio_t                     floor_prio,
  output logic                      win_hit,
  output logic [VEC_W-1:0]          win_idx,
  output prio_t                     win_prio
);
  prio_t prio_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign prio_arr[g] = prio_flat[g*PRIO_W +: PRIO_W];
  end

  // Strict compare while scanning upward keeps the lowest index on ties
  // and rejects anything not above the floor.
  always_comb begin
    win_hit  = 1'b0;
    win_idx  = '0;
    win_prio = floor_prio;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (prio_arr[i] > win_prio)) begin
        win_hit  = 1'b1;
        win_idx  = VEC_W'(i);
        win_prio = prio_arr[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_lifo.sv
module irq_prio_lifo
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 14
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  logic  pop,
  input  prio_t push_val,
  output prio_t top_val
);
  prio_t ent_q [DEPTH];
  prio_t ent_d [DEPTH];

  // Shift stack: index 0 is the top. A push drops the bottom entry off
  // the end, and a pop shifts zero in at the bottom, so an empty pop reads 0.
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    prio_t from_above;
    prio_t from_below;
    if (e == 0) begin : g_first
      assign from_above = push_val;
    end else begin : g_mid
      assign from_above = ent_q[e-1];
    end
    if (e == DEPTH-1) begin : g_last
      assign from_below = '0;
    end else begin : g_rest
      assign from_below = ent_q[e+1];
    end

    always_comb begin
      if (push)     ent_d[e] = from_above;
      else if (pop) ent_d[e] = from_below;
      else          ent_d[e] = ent_q[e];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ent_q[e] <= '0;
      else if (push || pop) ent_q[e] <= ent_d[e];
    end
  end

  assign top_val = ent_q[0];
endmodule

// File: rtl/irq_preempt_arb.sv
module irq_preempt_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STACK_DEPTH = 14,
  localparam int VEC_W      = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_req,
  input  logic [PRIO_W*NUM_SRC-1:0] src_prio,
  input  logic                      ack_rd,
  input  logic                      eoi_wr,
  output logic                      cpu_irq,
  output logic [VEC_W-1:0]          ack_vec,
  output logic [PRIO_W-1:0]         cur_prio
);
  logic             rst_i_n;
  logic             irq_q, irq_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  prio_t            vprio_q, vprio_d;
  prio_t            cur_q, cur_d;
  logic             win_hit;
  logic [VEC_W-1:0] win_idx;
  prio_t            win_prio;
  prio_t            lifo_top;
  logic             ack_take, eoi_take, irq_rise;
  logic             cur_en, vec_en;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i_n)
  );

  irq_win_sel #(.NUM_SRC(NUM_SRC)) u_sel (
    .req        (src_req),
    .prio_flat  (src_prio),
    .floor_prio (cur_q),
    .win_hit    (win_hit),
    .win_idx    (win_idx),
    .win_prio   (win_prio)
  );

  irq_prio_lifo #(.DEPTH(STACK_DEPTH)) u_lifo (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .push     (ack_take),
    .pop      (eoi_take),
    .push_val (cur_q),
    .top_val  (lifo_top)
  );

  always_comb begin
    ack_take = ack_rd & irq_q;
    eoi_take = eoi_wr & ~ack_take;
    irq_d    = ack_take ? 1'b0 : win_hit;
    irq_rise = irq_d & ~irq_q;
    vec_en   = irq_rise;
    vec_d    = win_idx;
    vprio_d  = win_prio;
    cur_en   = ack_take | eoi_take;
    cur_d    = ack_take ? vprio_q : lifo_top;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      irq_q   <= 1'b0;
      vec_q   <= '0;
      vprio_q <= '0;
      cur_q   <= '0;
    end else begin
      irq_q <= irq_d;
      if (vec_en) begin
        vec_q   <= vec_d;
        vprio_q <= vprio_d;
      end
      if (cur_en) cur_q <= cur_d;
    end
  end

  assign cpu_irq  = irq_q;
  assign ack_vec  = vec_q;
  assign cur_prio = cur_q;
endmodule

// File: rtl/irq_preempt_arb_chk.sv
module irq_preempt_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC-1:0]        src_req,
  input logic [PRIO_W*NUM_SRC-1:0] src_prio,
  input logic                      ack_rd,
  input logic                      eoi_wr,
  input logic                      cpu_irq,
  input logic [VEC_W-1:0]          ack_vec,
  input logic [PRIO_W-1:0]         cur_prio
);
  AST_RISE_REQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> ((($past(src_req) >> ack_vec) & NUM_SRC'(1)) != '0)); // R1
  AST_RISE_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> (PRIO_W'($past(src_prio) >> (int'(ack_vec) * PRIO_W)) > $past(cur_prio))); // R2
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cpu_irq) |-> $stable(ack_vec)); // R3
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && cpu_irq) |=> !cpu_irq); // R4
  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !cpu_irq && !eoi_wr) |=> $stable(cur_prio)); // R5
  AST_PRIO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_rd && !eoi_wr) |=> $stable(cur_prio)); // R6
  AST_TOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_prio == PRIO_TOP && !eoi_wr) |=> !cpu_irq); // R9
endmodule

bind irq_preempt_arb irq_preempt_arb_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_req  (src_req),
  .src_prio (src_prio),
  .ack_rd   (ack_rd),
  .eoi_wr   (eoi_wr),
  .cpu_irq  (cpu_irq),
  .ack_vec  (ack_vec),
  .cur_prio (cur_prio)
);

// File: tb/irq_preempt_arb_tb.sv
`timescale 1ns/1ps
module irq_preempt_arb_tb;
  localparam int NS = 8;
  localparam int SD = 14;
  localparam int VW = $clog2(NS);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NS-1:0]   src_req;
  logic [4*NS-1:0] src_prio;
  logic            ack_rd, eoi_wr;
  logic            cpu_irq;
  logic [VW-1:0]   ack_vec;
  logic [3:0]      cur_prio;
  logic [3:0]      bprio [NS];

  int checks = 0;
  int fails  = 0;
  int mcur;
  int mstk [SD];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NS; i++) src_prio[i*4 +: 4] = bprio[i];
  end

  irq_preempt_arb #(.NUM_SRC(NS), .STACK_DEPTH(SD)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_prio(src_prio),
    .ack_rd(ack_rd), .eoi_wr(eoi_wr), .cpu_irq(cpu_irq),
    .ack_vec(ack_vec), .cur_prio(cur_prio)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack_rd = 1'b1; step(1); ack_rd = 1'b0;
  endtask

  task automatic pulse_eoi();
    eoi_wr = 1'b1; step(1); eoi_wr = 1'b0;
  endtask

  function automatic int model_win(input logic [NS-1:0] pat, input int floor);
    int best = floor;
    int idx  = -1;
    for (int i = 0; i < NS; i++)
      if (pat[i] && int'(bprio[i]) > best) begin best = int'(bprio[i]); idx = i; end
    return idx;
  endfunction

  task automatic mpush(input int v);
    for (int i = SD-1; i > 0; i--) mstk[i] = mstk[i-1];
    mstk[0] = v;
  endtask

  task automatic mpop();
    mcur = mstk[0];
    for (int i = 0; i < SD-1; i++) mstk[i] = mstk[i+1];
    mstk[SD-1] = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w;
    rst_n = 1'b0; src_req = '0; ack_rd = 1'b0; eoi_wr = 1'b0;
    for (int i = 0; i < NS; i++) bprio[i] = 4'd0;
    for (int i = 0; i < SD; i++) mstk[i] = 0;
    mcur = 0;
    step(4); rst_n = 1'b1; step(4);

    chk(cpu_irq == 1'b0, "R1 reset irq", int'(cpu_irq), 0);
    chk(cur_prio == 4'd0, "R6 reset prio", int'(cur_prio), 0);
    chk(ack_vec == '0, "R3 reset vec", int'(ack_vec), 0);

    // Exhaustive request sweep, cur_prio = 0, two priority tables
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < NS; i++)
        bprio[i] = (t == 0) ? 4'((i * 5) % 8) : 4'((i / 2) * 5);
      for (int p = 0; p < (1 << NS); p++) begin
        src_req = '0; step(2);
        src_req = NS'(p); step(1);
        w = model_win(NS'(p), 0);
        chk(cpu_irq == (w >= 0), "R1 sweep irq", int'(cpu_irq), int'(w >= 0));
        if (w >= 0) chk(int'(ack_vec) == w, "R2 R3 sweep winner", int'(ack_vec), w);
      end
    end
    src_req = '0; step(2);

    // Vector hold, nested preemption, restore without re-search
    for (int i = 0; i < NS; i++) bprio[i] = 4'((i * 5) % 8);   // src2=2, src3=7
    src_req = NS'(1 << 2); step(2);
    chk(cpu_irq && ack_vec == VW'(2), "R3 first rise vec", int'(ack_vec), 2);
    src_req = NS'((1 << 2) | (1 << 3)); step(2);
    chk(cpu_irq == 1'b1, "R1 irq stays high", int'(cpu_irq), 1);
    chk(ack_vec == VW'(2), "R3 vec held while high", int'(ack_vec), 2);
    pulse_ack();
    chk(cur_prio == 4'd2, "R4 adopt latched prio", int'(cur_prio), 2);
    chk(cpu_irq == 1'b0, "R4 irq drops on ack", int'(cpu_irq), 0);
    step(1);
    chk(cpu_irq && ack_vec == VW'(3), "R3 preempt vec", int'(ack_vec), 3);
    pulse_ack();
    chk(cur_prio == 4'd7, "R4 nested prio", int'(cur_prio), 7);
    src_req = NS'(1 << 2);
    pulse_eoi();
    chk(cur_prio == 4'd2, "R6 restore prio", int'(cur_prio), 2);
    step(4);
    chk(cpu_irq == 1'b0, "R8 interrupted source silent", int'(cpu_irq), 0);
    pulse_eoi();
    chk(cur_prio == 4'd0, "R6 restore bottom", int'(cur_prio), 0);
    src_req = '0; step(3);

    // Ack while idle is ignored
    pulse_ack();
    chk(cur_prio == 4'd0, "R5 idle ack ignored", int'(cur_prio), 0);

    // Climb all levels on source 0, overflowing the save stack
    for (int i = 0; i < NS; i++) bprio[i] = 4'd0;
    src_req = NS'(1);
    mcur = 0;
    for (int k = 1; k <= 15; k++) begin
      bprio[0] = 4'(k); step(2);
      chk(cpu_irq && ack_vec == '0, "R1 climb rise", int'(cpu_irq), 1);
      pulse_ack();
      mpush(mcur); mcur = k;
      chk(int'(cur_prio) == mcur, "R4 climb prio", int'(cur_prio), mcur);
    end
    for (int i = 0; i < NS; i++) bprio[i] = 4'd15;
    src_req = '1; step(3);
    chk(cpu_irq == 1'b0, "R9 level 15 blocks", int'(cpu_irq), 0);
    pulse_ack();
    chk(cur_prio == 4'd15, "R5 ack at 15 ignored", int'(cur_prio), 15);
    src_req = '0; step(1);
    for (int k = 0; k < 16; k++) begin
      pulse_eoi();
      mpop();
      chk(int'(cur_prio) == mcur, "R7 unwind", int'(cur_prio), mcur);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule